// File: doc/BRIEF.md
# Dual-Channel Compare Timer

This block is a small register-mapped timer with two identical 32-bit channels. Each channel owns an up-counter, a compare value and a control word. While its count enable is set, a channel's counter steps by one on every clock. It wraps from all-ones to zero. When the counter equals the compare value on an enabled clock edge, the channel latches a pending flag. The channel's interrupt line is high whenever that flag and the channel's interrupt enable are both set.

Software reaches the block through a plain 32-bit register port: an address, a write strobe with write data, and read data that follows the address combinationally. The two channels sit in one window at a fixed stride. Software can load the counter directly, for example to zero before arming an event. It can rewrite the compare value at any moment. It acknowledges an event by writing a one to the pending bit. The asynchronous reset input is released to the logic through a two-flop synchronizer, so the block leaves reset two clock edges after the input rises.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset every register of both channels reads zero and both interrupt lines are low.
- R2: Channel n occupies byte addresses 0x08 + 12*n: control at +0, compare at +4, count at +8. Control bit 0 is the pending flag, bit 1 the interrupt enable, bit 2 the count enable. Control bits 31..3 read as zero.
- R3: A channel's counter increases by one per clock while its count enable (control bit 2) is set, and holds its value while it is clear.
- R4: A write to the count register loads the written value, taking precedence over that cycle's increment.
- R5: The compare register takes any write at any time. A match happens on a clock edge where the count enable is set and the counter equals the compare value, and it sets the pending flag at that edge.
- R6: Writing control with bit 0 = 1 clears the pending flag. Writing it with bit 0 = 0 leaves the flag unchanged. In both cases bits 1 and 2 are updated from the written data.
- R7: When a match and a clearing write to control fall on the same edge, the pending flag ends up set.
- R8: A channel's interrupt output is high exactly when its pending flag and its interrupt enable are both set.
- R9: The counter wraps from 0xFFFFFFFF to 0 and keeps counting, and a compare value of 0xFFFFFFFF or of a value past the wrap still matches.
- R10: Reads from any address that is not one of the six registers return zero. Writes to such addresses change no register.
- R11: A counter loaded with 0 and armed with a compare value of 15 produces exactly one match, 16 enabled edges after counting starts, and no second match before the counter wraps.
- R12: Writes to one channel never alter the other channel's registers or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 2 | Per-channel interrupt lines, bit n for channel n |

## Verification
The hardest situation to reach from the ports is a clearing write to control that lands on exactly the edge where the counter meets the compare value. The stimulus reaches it by loading the count register with one less than the compare value and idling for one cycle. It then issues the clearing write, so that the write and the match share an edge. Wrap and large-delta behaviour cannot be reached by waiting out 2^32 cycles. Instead the count register is preloaded a few steps below all-ones, with compare values at all-ones and just beyond the wrap. A behavioural model tracks both channels and is compared on every clock, so any stray update to an idle channel also shows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // control word field positions
  localparam int unsigned CTL_PEND_BIT = 0;
  localparam int unsigned CTL_IE_BIT   = 1;
  localparam int unsigned CTL_CE_BIT   = 2;
  // register offsets inside one channel
  localparam int unsigned OFS_CTL = 0;
  localparam int unsigned OFS_CMP = 4;
  localparam int unsigned OFS_CNT = 8;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_ctl,
  output logic              sel_cmp,
  output logic              sel_cnt
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(BASE + OFS_CTL);
  localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(BASE + OFS_CMP);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(BASE + OFS_CNT);

  always_comb begin
    sel_ctl = (addr == A_CTL);
    sel_cmp = (addr == A_CMP);
    sel_cnt = (addr == A_CNT);
  end

  // R2: at most one register of a channel answers an address
  always_comb begin
    a_r2_one_reg: assert ($onehot0({sel_ctl, sel_cmp, sel_cnt}));
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          sel_ctl,
  input  logic          sel_cmp,
  input  logic          sel_cnt,
  output logic [DW-1:0] rd_word,
  output logic          irq
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] cmp_q, cmp_d;
  logic          pend_q, pend_d;
  logic          ie_q, ie_d;
  logic          ce_q, ce_d;
  logic          ctl_wr, cmp_wr, cnt_wr;
  logic          clr_req, match;
  logic [DW-1:0] ctl_word;

  // next-state
  always_comb begin
    ctl_wr  = wr_en & sel_ctl;
    cmp_wr  = wr_en & sel_cmp;
    cnt_wr  = wr_en & sel_cnt;
    match   = ce_q & (cnt_q == cmp_q);
    clr_req = ctl_wr & wdata[CTL_PEND_BIT];

    ie_d    = ctl_wr ? wdata[CTL_IE_BIT] : ie_q;
    ce_d    = ctl_wr ? wdata[CTL_CE_BIT] : ce_q;
    cmp_d   = cmp_wr ? wdata : cmp_q;

    if (match)        pend_d = 1'b1;
    else if (clr_req) pend_d = 1'b0;
    else              pend_d = pend_q;

    if (cnt_wr)       cnt_d = wdata;
    else if (ce_q)    cnt_d = cnt_q + ONE;
    else              cnt_d = cnt_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      pend_q <= 1'b0;
      ie_q   <= 1'b0;
      ce_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
      pend_q <= pend_d;
      ie_q   <= ie_d;
      ce_q   <= ce_d;
    end
  end

  always_comb begin
    ctl_word               = '0;
    ctl_word[CTL_PEND_BIT] = pend_q;
    ctl_word[CTL_IE_BIT]   = ie_q;
    ctl_word[CTL_CE_BIT]   = ce_q;
    if (sel_ctl)      rd_word = ctl_word;
    else if (sel_cmp) rd_word = cmp_q;
    else if (sel_cnt) rd_word = cnt_q;
    else              rd_word = '0;
  end

  assign irq = pend_q & ie_q;

  // R3: counting follows the enable
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && !cnt_wr) |=> (cnt_q == $past(cnt_q) + ONE));
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_q && !cnt_wr) |=> $stable(cnt_q));
  // R4: direct load
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wdata)));
  // R5 and R7: a match always leaves the flag set
  a_r7_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pend_q);
  // R6: clear works, and the flag holds without a clear
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !match) |=> !pend_q);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_req) |=> pend_q);
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux #(
  parameter int unsigned DW     = 32,
  parameter int unsigned NUM_CH = 2
) (
  input  logic [NUM_CH-1:0][DW-1:0] words,
  output logic [DW-1:0]             rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) rdata = rdata | words[i];
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int unsigned DW        = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned CH_BASE   = 8,
  parameter int unsigned CH_STRIDE = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic                     rst_n_int;
  logic [NUM_CH-1:0][DW-1:0] ch_words;
  logic [NUM_CH-1:0]        ch_hit;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int unsigned CB = CH_BASE + g * CH_STRIDE;
    logic s_ctl, s_cmp, s_cnt;

    tmr_addr_dec #(.ADDR_W(ADDR_W), .BASE(CB)) u_dec (
      .addr   (bus_addr),
      .sel_ctl(s_ctl),
      .sel_cmp(s_cmp),
      .sel_cnt(s_cnt)
    );

    tmr_channel #(.DW(DW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .wr_en  (bus_wr),
      .wdata  (bus_wdata),
      .sel_ctl(s_ctl),
      .sel_cmp(s_cmp),
      .sel_cnt(s_cnt),
      .rd_word(ch_words[g]),
      .irq    (irq[g])
    );

    assign ch_hit[g] = s_ctl | s_cmp | s_cnt;
  end

  tmr_rd_mux #(.DW(DW), .NUM_CH(NUM_CH)) u_mux (
    .words(ch_words),
    .rdata(bus_rdata)
  );

  // R10: an address no channel claims reads zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ch_hit == '0) |-> (bus_rdata == '0));
  // R12: the channel windows never overlap
  a_r12_disjoint: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(ch_hit));
endmodule

// File: tb/sim_dual_cmp_timer.sv
module sim_dual_cmp_timer;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int vec, bad;
  bit done;
  string cur_req;

  // behavioural reference state
  bit [31:0] m_cnt [2];
  bit [31:0] m_cmp [2];
  bit        m_pe  [2];
  bit        m_ie  [2];
  bit        m_ce  [2];

  dual_cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit [7:0] base_of(int ch);
    return 8'(8 + 12 * ch);
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a);
    bit [31:0] r = 32'h0;
    for (int ch = 0; ch < 2; ch++) begin
      if (a == base_of(ch))      r = {29'h0, m_ce[ch], m_ie[ch], m_pe[ch]};
      if (a == base_of(ch) + 4)  r = m_cmp[ch];
      if (a == base_of(ch) + 8)  r = m_cnt[ch];
    end
    return r;
  endfunction

  task automatic model_edge();
    for (int ch = 0; ch < 2; ch++) begin
      bit hit_c = bus_wr && (bus_addr == base_of(ch));
      bit hit_m = bus_wr && (bus_addr == base_of(ch) + 4);
      bit hit_n = bus_wr && (bus_addr == base_of(ch) + 8);
      bit fire  = m_ce[ch] && (m_cnt[ch] == m_cmp[ch]);
      bit old_ce = m_ce[ch];
      if (fire) m_pe[ch] = 1;
      else if (hit_c && bus_wdata[0]) m_pe[ch] = 0;
      if (hit_c) begin
        m_ie[ch] = bus_wdata[1];
        m_ce[ch] = bus_wdata[2];
      end
      if (hit_m) m_cmp[ch] = bus_wdata;
      if (hit_n) m_cnt[ch] = bus_wdata;
      else if (old_ce) m_cnt[ch] = m_cnt[ch] + 1;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    vec++;
    if (bus_rdata !== m_read(bus_addr)) begin
      bad++;
      $display("FAIL %s rdata @%02h: got %08h expected %08h",
               cur_req, bus_addr, bus_rdata, m_read(bus_addr));
    end
    if (irq !== {m_pe[1] & m_ie[1], m_pe[0] & m_ie[0]}) begin
      bad++;
      $display("FAIL %s irq: got %b expected %b", cur_req, irq,
               {m_pe[1] & m_ie[1], m_pe[0] & m_ie[0]});
    end
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd(input bit [7:0] a, input int n);
    bus_addr = a;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sweep();
    for (int ch = 0; ch < 2; ch++)
      for (int r = 0; r < 3; r++) rd(base_of(ch) + 8'(4 * r), 1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    vec = 0; bad = 0; done = 0;
    bus_addr = 8'h0; bus_wr = 1'b0; bus_wdata = 32'h0;
    for (int ch = 0; ch < 2; ch++) begin
      m_cnt[ch] = 0; m_cmp[ch] = 0; m_pe[ch] = 0; m_ie[ch] = 0; m_ce[ch] = 0;
    end
    rst_n = 1'b0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h00, 4);
    sweep();                                 // R1 reset state

    cur_req = "R2";                          // upper ctl bits ignored, bit0 clear
    wr(base_of(0), 32'hFFFF_FFFA);           // ce=0 ie=1 pend write 0
    rd(base_of(0), 2);
    wr(base_of(0), 32'h0000_0000);
    wr(base_of(0) + 4, 32'h1234_5678);
    wr(base_of(1) + 4, 32'h9ABC_DEF0);
    sweep();

    cur_req = "R3";                          // counting and holding
    wr(base_of(0) + 4, 32'h0000_1000);
    wr(base_of(0), 32'h4);
    rd(base_of(0) + 8, 6);
    wr(base_of(0), 32'h0);
    rd(base_of(0) + 8, 4);

    cur_req = "R4";                          // load while counting
    wr(base_of(0), 32'h4);
    wr(base_of(0) + 8, 32'h0000_0500);
    rd(base_of(0) + 8, 3);

    cur_req = "R11";                         // delta 15, one match
    wr(base_of(0), 32'h1);                   // stop, clear pending
    wr(base_of(0) + 8, 32'h0);
    wr(base_of(0) + 4, 32'd15);
    wr(base_of(0), 32'h6);
    rd(base_of(0), 20);
    cur_req = "R5";
    rd(base_of(0), 1);
    cur_req = "R6";
    wr(base_of(0), 32'h6);                   // write 0 to bit0 keeps flag
    rd(base_of(0), 2);
    wr(base_of(0), 32'h7);                   // write 1 clears
    rd(base_of(0), 2);
    cur_req = "R11";
    rd(base_of(0), 30);                      // no second match

    cur_req = "R7";                          // clear and match on one edge
    wr(base_of(0) + 4, 32'd100);
    wr(base_of(0) + 8, 32'd99);
    rd(base_of(0), 1);
    wr(base_of(0), 32'h7);
    rd(base_of(0), 2);
    wr(base_of(0), 32'h7);
    rd(base_of(0), 2);

    cur_req = "R8";                          // irq gated by enable
    wr(base_of(0) + 8, 32'd95);
    wr(base_of(0), 32'h4);                   // ie off
    rd(base_of(0), 8);
    wr(base_of(0), 32'h6);                   // ie on, flag still set
    rd(base_of(0), 3);
    wr(base_of(0), 32'h0);

    cur_req = "R9";                          // wrap, top match, past-wrap match
    wr(base_of(1) + 4, 32'hFFFF_FFFF);
    wr(base_of(1) + 8, 32'hFFFF_FFF8);
    wr(base_of(1), 32'h6);
    rd(base_of(1) + 8, 12);
    wr(base_of(1), 32'h7);
    wr(base_of(1) + 4, 32'h0000_0003);
    wr(base_of(1) + 8, 32'hFFFF_FFFC);
    rd(base_of(1), 12);

    cur_req = "R12";                         // ch0 traffic leaves ch1 alone
    wr(base_of(0), 32'h7);
    wr(base_of(0) + 8, 32'h0);
    wr(base_of(0) + 4, 32'h5);
    rd(base_of(1), 10);
    sweep();

    cur_req = "R10";                         // unmapped addresses
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h0A, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'h00, 1); rd(8'h04, 1); rd(8'h0A, 1); rd(8'h20, 1); rd(8'hFC, 1);
    sweep();

    done = 1;
    summary();
    $finish;
  end
endmodule